// File: doc/BRIEF.md
# Transmit Frame Length Counter

This block keeps the byte length that software programs for outgoing frames and tracks how many payload bytes of the current frame are still to be sent. The programmed length covers payload only; any check bytes the transmitter appends afterwards are not part of it. Software reaches the 13-bit setting through an 8-bit register port that spans two adjacent addresses. The low address carries bits 7..0. The high address carries bits 12..8 in data bits 4..0.

The transmit datapath drives two single-cycle strobes. `frame_start` reloads the live counter from the programmed length. `byte_sent` takes one off the counter. The block drives the remaining count and a flag that marks the final byte. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: every strobe is accepted in the cycle it is high.

A read returns the programmed length when `test_mode` is 1, and the live count when it is 0. Writes are held until the high byte arrives, and count reads are snapshotted at the low byte, so each 13-bit value moves as one consistent unit.

Top module: `tx_frame_len_counter`

## Requirements
- R1: After reset the programmed length is 0x800, the remaining count is 0 and `last_byte` is 0.
- R2: A write to address 0 only stages its data, and the programmed length is unchanged. A write to address 1 commits the length as {wdata[4:0], staged byte}. wdata[7:5] of that write are ignored. A frame start between the two writes loads the old length.
- R3: A `frame_start` pulse makes `remaining` equal the programmed length on the next cycle. If `byte_sent` is high in the same cycle, the load wins.
- R4: Each `byte_sent` pulse without `frame_start` lowers a nonzero `remaining` by exactly 1 on the next cycle, with borrow across all 13 bits.
- R5: At zero, further `byte_sent` pulses leave `remaining` at 0. The counter never wraps.
- R6: `last_byte` is 1 exactly when `remaining` equals 1.
- R7: Address 0 (reg_addr=0) reads bits 7..0 of the selected value. Address 1 (reg_addr=1) reads bits 12..8 on rdata[4:0], with rdata[7:5] always 0. `rdata` is valid in the cycle `reg_rd` is high.
- R8: With `test_mode`=1, reads return the programmed length.
- R9: With `test_mode`=0, a read of address 0 returns count bits 7..0 and captures count bits 12..8. The next read of address 1 returns that captured value even if the count has changed since.
- R10: Register writes change only the programmed length, in either test mode, and never disturb a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = low byte address, 1 = high byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| test_mode | input | 1 | 1 = reads return the programmed length, 0 = the live count |
| frame_start | input | 1 | Frame start strobe from the transmit datapath |
| byte_sent | input | 1 | One payload byte transmitted |
| remaining | output | 13 | Bytes still to send in the current frame |
| last_byte | output | 1 | High when one byte remains |

## Verification
The countdown is swept over every length from 1 to 20 and over boundary lengths around the byte carry (0xFF, 0x100, 0x101), the reset value 0x800 and the maximum 0x1FFF. Each step is compared against the length minus the bytes sent, which separates correct borrow from low-byte-only decrement and separates the `last_byte` position from off-by-one variants. Extra strobes at zero, a same-cycle start with a byte strobe, and a frame start between the two write halves distinguish saturation, load priority and staged commit. A count read split across a borrow from 0x100 to 0xFF distinguishes a snapshotted high byte from a live one.

// File: rtl/txlen_pkg.sv
package txlen_pkg;
  typedef enum logic {
    ADDR_LO = 1'b0,
    ADDR_HI = 1'b1
  } txlen_addr_e;

  localparam int unsigned TXLEN_CNT_W  = 13;
  localparam int unsigned TXLEN_DATA_W = 8;
endpackage

// File: rtl/txlen_prog_reg.sv
module txlen_prog_reg
  import txlen_pkg::*;
#(
  parameter int unsigned CNT_W  = TXLEN_CNT_W,
  parameter int unsigned DATA_W = TXLEN_DATA_W,
  parameter logic [CNT_W-1:0] RESET_LEN = 'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  txlen_addr_e       addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  len_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] stage_q;
  logic [CNT_W-1:0]  len_q;
  logic              unused_rsvd;

  // reserved upper bits of a high-byte write are discarded
  assign unused_rsvd = ^wdata[DATA_W-1:HI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      len_q   <= RESET_LEN;
    end else if (wr_en) begin
      if (addr == ADDR_LO) stage_q <= wdata;
      else                 len_q   <= {wdata[HI_W-1:0], stage_q};
    end
  end

  assign len_o = len_q;

  // R2: a low-byte write alone leaves the committed length alone
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_LO) |=> $stable(len_o));

  // R2: low then high write yields low byte from the first write
  p_commit_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_LO) ##1 (wr_en && addr == ADDR_HI)
      |=> len_o[DATA_W-1:0] == $past(wdata, 2));

  // R10: no write, no change
  p_len_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(len_o));
endmodule

// File: rtl/txlen_down_counter.sv
module txlen_down_counter
  import txlen_pkg::*;
#(
  parameter int unsigned CNT_W = TXLEN_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (dec && !at_zero)  cnt_q <= cnt_q - ONE;
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == ONE);

  // R3: load takes effect next cycle, even with a concurrent decrement
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_o == $past(load_val));

  // R4: single-step decrement
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && count_o != '0) |=> count_o == $past(count_o) - ONE);

  // R5: floor at zero
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && count_o == '0) |=> count_o == '0);

  // R10: counter idles without a strobe
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(count_o));

  // R6: a decrement from the last byte ends at zero
  p_last_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && dec && !load) |=> count_o == '0);
endmodule

// File: rtl/txlen_read_path.sv
module txlen_read_path
  import txlen_pkg::*;
#(
  parameter int unsigned CNT_W  = TXLEN_CNT_W,
  parameter int unsigned DATA_W = TXLEN_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  txlen_addr_e       addr,
  input  logic              test_mode,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0] shadow_q;
  logic [HI_W-1:0] hi_field;
  logic            snap;

  assign snap = rd_en && (addr == ADDR_LO) && !test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (snap) shadow_q <= count_i[CNT_W-1:DATA_W];
  end

  assign hi_field = test_mode ? len_i[CNT_W-1:DATA_W] : shadow_q;

  always_comb begin
    if (addr == ADDR_LO)
      rdata_o = test_mode ? len_i[DATA_W-1:0] : count_i[DATA_W-1:0];
    else
      rdata_o = DATA_W'(hi_field);
  end

  // R9: low read followed by high read returns the snapshot taken at the low read
  p_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snap ##1 (rd_en && addr == ADDR_HI && !test_mode)
      |-> rdata_o == DATA_W'($past(count_i[CNT_W-1:DATA_W])));

  // R8: test-mode reads track the programmed length
  p_test_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && test_mode && addr == ADDR_LO) |-> rdata_o == len_i[DATA_W-1:0]);

  // R7: reserved read bits are zero
  p_hi_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_HI) |-> (rdata_o >> HI_W) == '0);
endmodule

// File: rtl/tx_frame_len_counter.sv
module tx_frame_len_counter
  import txlen_pkg::*;
#(
  parameter int unsigned CNT_W  = TXLEN_CNT_W,
  parameter int unsigned DATA_W = TXLEN_DATA_W,
  parameter logic [CNT_W-1:0] RESET_LEN = 'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              test_mode,
  input  logic              frame_start,
  input  logic              byte_sent,
  output logic [CNT_W-1:0]  remaining,
  output logic              last_byte
);
  txlen_addr_e      addr;
  logic [CNT_W-1:0] prog_len;
  logic [CNT_W-1:0] live_cnt;

  assign addr = txlen_addr_e'(reg_addr);

  txlen_prog_reg #(
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .RESET_LEN (RESET_LEN)
  ) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (addr),
    .wdata (reg_wdata),
    .len_o (prog_len)
  );

  txlen_down_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .dec      (byte_sent),
    .load_val (prog_len),
    .count_o  (live_cnt),
    .last_o   (last_byte)
  );

  txlen_read_path #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd),
    .addr      (addr),
    .test_mode (test_mode),
    .len_i     (prog_len),
    .count_i   (live_cnt),
    .rdata_o   (reg_rdata)
  );

  assign remaining = live_cnt;

  // R10: register writes never move the live count
  p_write_no_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !frame_start && !byte_sent) |=> $stable(remaining));
endmodule

// File: tb/tx_frame_len_counter_tb.sv
module tx_frame_len_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       test_mode = 0, frame_start = 0, byte_sent = 0;
  logic [12:0] remaining;
  logic       last_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tx_frame_len_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .test_mode(test_mode), .frame_start(frame_start), .byte_sent(byte_sent),
    .remaining(remaining), .last_byte(last_byte)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks enter and leave just after a falling edge
  task automatic wr_reg(bit hi, logic [7:0] d);
    reg_wr = 1; reg_addr = hi; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(bit hi, output logic [7:0] d);
    reg_rd = 1; reg_addr = hi;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic program_len(int len, bit junk);
    wr_reg(0, len[7:0]);
    wr_reg(1, {(junk ? 3'b101 : 3'b000), len[12:8]});
  endtask

  task automatic read_len(output int v);
    logic [7:0] lo, hi;
    test_mode = 1;
    rd_reg(0, lo);
    rd_reg(1, hi);
    test_mode = 0;
    v = {hi, lo};
  endtask

  task automatic pulse(bit st, bit bs);
    frame_start = st; byte_sent = bs;
    @(negedge clk);
    frame_start = 0; byte_sent = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    logic [7:0] b;
    int lens[26];
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 remaining", remaining, 0);
    chk("R1 last_byte", last_byte, 0);
    read_len(v);
    chk("R1 reset length", v, 'h800);
    rd_reg(0, b); chk("R7 count lo", b, 0);
    rd_reg(1, b); chk("R7 count hi", b, 0);

    // R2 staging: low write alone does not commit
    wr_reg(0, 8'h05);
    read_len(v);
    chk("R2 staged not committed", v, 'h800);
    pulse(1, 0);
    chk("R2 start between halves loads old", remaining, 'h800);
    wr_reg(1, 8'hE0);
    read_len(v);
    chk("R2 commit ignores reserved bits", v, 'h005);

    // sweep lengths
    for (int i = 0; i < 20; i++) lens[i] = i + 1;
    lens[20] = 'h0FF; lens[21] = 'h100; lens[22] = 'h101;
    lens[23] = 'h800; lens[24] = 'h1FFF; lens[25] = 'h013;
    for (int i = 0; i < 26; i++) begin
      int len = lens[i];
      program_len(len, i[0]);
      read_len(v);
      chk("R8 test read length", v, len);
      pulse(1, 0);
      chk("R3 load", remaining, len);
      chk("R6 last at load", last_byte, (len == 1) ? 1 : 0);
      for (int k = 1; k <= len; k++) begin
        pulse(0, 1);
        chk("R4 decrement", remaining, len - k);
        chk("R6 last flag", last_byte, (len - k == 1) ? 1 : 0);
      end
      pulse(0, 1);
      pulse(0, 1);
      chk("R5 floor at zero", remaining, 0);
      chk("R5 last clear at zero", last_byte, 0);
    end

    // R9 snapshot across a borrow
    program_len('h100, 0);
    pulse(1, 0);
    rd_reg(0, b); chk("R9 count lo", b, 'h00);
    pulse(0, 1);
    rd_reg(1, b); chk("R9 hi from snapshot", b, 'h01);
    rd_reg(0, b); chk("R9 count lo after dec", b, 'hFF);
    rd_reg(1, b); chk("R9 hi new snapshot", b, 'h00);

    // R7 maximum value field placement
    program_len('h1FFF, 0);
    pulse(1, 0);
    rd_reg(0, b); chk("R7 lo of max", b, 'hFF);
    rd_reg(1, b); chk("R7 hi of max padded", b, 'h1F);

    // R3 load beats concurrent decrement
    program_len(7, 0);
    pulse(1, 0);
    pulse(0, 1);
    pulse(0, 1);
    chk("R4 two steps", remaining, 5);
    pulse(1, 1);
    chk("R3 load priority", remaining, 7);

    // R10 writes during a frame, in test mode
    test_mode = 1;
    wr_reg(0, 8'h33);
    wr_reg(1, 8'h01);
    test_mode = 0;
    chk("R10 count undisturbed", remaining, 7);
    read_len(v);
    chk("R10 write in test mode commits", v, 'h133);
    pulse(1, 0);
    chk("R10 new length loads", remaining, 'h133);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule